// File: doc/BRIEF.md
# Start-of-Frame Indication Pulse Generator

This block watches the receive and transmit data paths between an Ethernet PHY and MAC for the start-frame delimiter. When it finds one, it waits for a programmable delay and then raises a pulse. The pulse tells the MAC that a frame has just begun, so that precision-time-protocol software can timestamp the frame more accurately. Each link speed has its own delay value. Receive delays count receive-symbol strobes. Transmit delays count an 8 ns reference strobe.

The block runs on a single system clock. The receive symbol rate and the 8 ns reference arrive as one-cycle enable strobes. A small register file, reached through a simple synchronous read/write port, holds:
- the enables,
- the pulse-length options,
- the per-speed delay fields,
- a function select for each of four general-purpose output pins.

Each pin can carry its own default function, link status, carrier sense, collision, or one of the two indication pulses. The pin multiplexer lets each pulse appear on at most one pin. A duplicate selection is recorded in a sticky status bit.

Top module: `sop_indicator`

## Requirements
- R1: A delimiter is recognised only on a symbol strobe with the path valid/enable input high. In nibble mode (speed code 0 = 10 Mb/s, 1 = 100 Mb/s) the current nibble must be 0xD on data bits [3:0], and the previous strobed symbol must have been a valid 0x5 nibble. In byte mode (speed codes 2 and 3 = 1000 Mb/s) the current byte must be 0xD5 and the previous strobed symbol must have been a valid 0x55.
- R2: The receive delay register (address 1) holds 10 Mb/s in bits [15:11], 100 Mb/s in bits [10:6] and 1000 Mb/s in bits [5:0]. The field for the present speed is loaded, and the pulse starts on the clock after the D-th `rx_sym_en` strobe that follows the delimiter edge. When D = 0, the pulse starts on the clock after the delimiter edge itself.
- R3: The transmit delay register (address 2) holds 10 Mb/s in bits [12:8], 100 Mb/s in bits [7:4] and 1000 Mb/s in bits [3:0]. The selected field counts `tick_8ns` strobes, with the same start rule as R2.
- R4: The control register is at address 0, with bit 0 = transmit enable, bit 1 = receive enable and bit 2 = delimiter trigger enable. A path triggers only when its own enable and bit 2 are both set.
- R5: When control bit 3 is clear, a pulse lasts one clock. When bit 3 is set, a pulse lasts 8×(bits[6:4]+1) clocks.
- R6: A delimiter that arrives while that path is still counting or pulsing is ignored. The pending pulse keeps its original timing, and no extra pulse follows.
- R7: Pin selects for pins 0 to 3 are at addresses 3 to 6. Pins 0 to 2 have 3-bit selects and pin 3 has a 4-bit select.
- R8: The pin select codes are: 0 = `dflt_fn[i]`, 1 = `link_up`, 2 = transmit pulse, 3 = receive pulse, 4 = `crs`, 5 = `col`. Any other code drives 0.
- R9: If more than one pin selects the same pulse code, only the lowest-numbered of those pins carries the pulse, and the others drive 0. While such a duplicate exists, status bit 0 (address 7) becomes set and stays set. Writing 1 to that bit clears it once the duplicate is gone.
- R10: Read data appears on `reg_rdata` one clock after `reg_rd`. Bits that are not implemented read as 0. All registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 16 | Registered read data |
| speed | input | 2 | Link speed code (0 = 10, 1 = 100, 2/3 = 1000 Mb/s) |
| rx_sym_en | input | 1 | Receive symbol strobe; also the receive delay unit |
| rx_dv | input | 1 | Receive data valid |
| rxd | input | 8 | Receive data |
| tx_sym_en | input | 1 | Transmit symbol strobe |
| tx_en | input | 1 | Transmit enable |
| txd | input | 8 | Transmit data |
| tick_8ns | input | 1 | 8 ns reference strobe; the transmit delay unit |
| link_up | input | 1 | Link status source for the pins |
| crs | input | 1 | Carrier sense source for the pins |
| col | input | 1 | Collision source for the pins |
| dflt_fn | input | 4 | Default function value for each pin |
| pin_out | output | 4 | General-purpose output pins |

## Verification
The main function is driven by a table of frames. The rows cover both paths, all three speeds, zero and maximum delays, short and long pulses, and every pin. The unused delay fields always hold a different value from the selected field, so a wrong speed decode or wrong field slice shows up as a wrong latency.

Directed frames cover the following cases, each of which isolates one qualifier or one timing rule:
- a missing preamble symbol;
- a low valid signal on the delimiter;
- a cleared path enable;
- a cleared trigger enable;
- strobes arriving only every second clock, which separates counting strobes from counting clocks;
- a burst of further delimiters during the wait, which separates ignoring a retrigger from restarting the count.

// File: rtl/sop_pkg.sv
package sop_pkg;
  localparam int NPIN = 4;
  localparam int DW   = 6;   // delay counter width
  localparam int LW   = 7;   // pulse length counter width

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_RXD  = 3'd1;
  localparam logic [2:0] A_TXD  = 3'd2;
  localparam logic [2:0] A_SEL0 = 3'd3;
  localparam logic [2:0] A_STAT = 3'd7;

  localparam logic [3:0] FN_DFLT = 4'd0;
  localparam logic [3:0] FN_LINK = 4'd1;
  localparam logic [3:0] FN_TXP  = 4'd2;
  localparam logic [3:0] FN_RXP  = 4'd3;
  localparam logic [3:0] FN_CRS  = 4'd4;
  localparam logic [3:0] FN_COL  = 4'd5;

  function automatic logic [DW-1:0] rx_delay_pick(logic [15:0] r, logic [1:0] spd);
    case (spd)
      2'd0:    return {1'b0, r[15:11]};
      2'd1:    return {1'b0, r[10:6]};
      default: return r[5:0];
    endcase
  endfunction

  function automatic logic [DW-1:0] tx_delay_pick(logic [12:0] r, logic [1:0] spd);
    case (spd)
      2'd0:    return {1'b0, r[12:8]};
      2'd1:    return {2'b0, r[7:4]};
      default: return {2'b0, r[3:0]};
    endcase
  endfunction

  function automatic logic [LW-1:0] pulse_len(logic long_en, logic [2:0] n);
    return long_en ? (LW'({n, 3'b000}) + LW'(8)) : LW'(1);
  endfunction
endpackage

// File: rtl/sop_detect.sv
module sop_detect (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sym_en,
  input  logic       valid,
  input  logic [7:0] data,
  input  logic       wide,
  output logic       hit
);
  logic prev_pre_q;
  logic is_pre, is_sfd;

  assign is_pre = wide ? (data == 8'h55) : (data[3:0] == 4'h5);
  assign is_sfd = wide ? (data == 8'hD5) : (data[3:0] == 4'hD);
  assign hit    = sym_en && valid && is_sfd && prev_pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      prev_pre_q <= 1'b0;
    else if (sym_en) prev_pre_q <= valid && is_pre;
  end
endmodule

// File: rtl/sop_pulse.sv
module sop_pulse
  import sop_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig,
  input  logic          tick,
  input  logic [DW-1:0] delay,
  input  logic [LW-1:0] len,
  output logic          pulse
);
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_FIRE} st_t;
  st_t           st_q;
  logic [DW-1:0] cnt_q;
  logic [LW-1:0] len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      len_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (trig) begin
          len_q <= len;
          cnt_q <= delay;
          st_q  <= (delay == '0) ? ST_FIRE : ST_WAIT;
        end
        ST_WAIT: if (tick) begin
          if (cnt_q == DW'(1)) st_q <= ST_FIRE;
          else                 cnt_q <= cnt_q - DW'(1);
        end
        default: begin
          if (len_q == LW'(1)) st_q <= ST_IDLE;
          else                 len_q <= len_q - LW'(1);
        end
      endcase
    end
  end

  assign pulse = (st_q == ST_FIRE);

  assert_wait_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT) |-> (cnt_q != '0));
  assert_ignore_retrigger_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && trig && !tick) |=> (st_q == ST_WAIT && $stable(cnt_q)));
  assert_short_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && trig && delay == '0 && len == LW'(1)) |=> pulse ##1 !pulse);
endmodule

// File: rtl/sop_regs.sv
module sop_regs
  import sop_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           addr,
  input  logic                 wr,
  input  logic [15:0]          wdata,
  input  logic                 rd,
  output logic [15:0]          rdata,
  input  logic                 conflict_set,
  output logic [6:0]           ctrl,
  output logic [15:0]          rx_dly,
  output logic [12:0]          tx_dly,
  output logic [NPIN-1:0][3:0] pin_sel
);
  logic [6:0]  ctrl_q;
  logic [15:0] rx_q;
  logic [12:0] tx_q;
  logic [3:0]  sel_q [NPIN];
  logic        conflict_q;
  logic        clr_wr;

  assign clr_wr = wr && addr == A_STAT && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
    end else if (wr) begin
      if (addr == A_CTRL) ctrl_q <= wdata[6:0];
      if (addr == A_RXD)  rx_q   <= wdata;
      if (addr == A_TXD)  tx_q   <= wdata[12:0];
    end
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_sel
    localparam logic [3:0] MASK = (i == NPIN - 1) ? 4'hF : 4'h7;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          sel_q[i] <= '0;
      else if (wr && addr == 3'(A_SEL0 + i)) sel_q[i] <= wdata[3:0] & MASK;
    end
    assign pin_sel[i] = sel_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            conflict_q <= 1'b0;
    else if (conflict_set) conflict_q <= 1'b1;
    else if (clr_wr)       conflict_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (rd) begin
      case (addr)
        A_CTRL:  rdata <= {9'b0, ctrl_q};
        A_RXD:   rdata <= rx_q;
        A_TXD:   rdata <= {3'b0, tx_q};
        3'd3:    rdata <= {12'b0, sel_q[0]};
        3'd4:    rdata <= {12'b0, sel_q[1]};
        3'd5:    rdata <= {12'b0, sel_q[2]};
        3'd6:    rdata <= {12'b0, sel_q[3]};
        default: rdata <= {15'b0, conflict_q};
      endcase
    end
  end

  assign ctrl   = ctrl_q;
  assign rx_dly = rx_q;
  assign tx_dly = tx_q;

  assert_conflict_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (conflict_q && !clr_wr) |=> conflict_q);
endmodule

// File: rtl/sop_pinmux.sv
module sop_pinmux
  import sop_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPIN-1:0][3:0] pin_sel,
  input  logic [NPIN-1:0]      dflt_fn,
  input  logic                 link_up,
  input  logic                 crs,
  input  logic                 col,
  input  logic                 rx_p,
  input  logic                 tx_p,
  output logic [NPIN-1:0]      pin_out,
  output logic                 conflict
);
  logic [NPIN-1:0] rx_pins;

  always_comb begin
    logic rx_seen, tx_seen;
    rx_seen  = 1'b0;
    tx_seen  = 1'b0;
    conflict = 1'b0;
    pin_out  = '0;
    rx_pins  = '0;
    for (int i = 0; i < NPIN; i++) begin
      case (pin_sel[i])
        FN_DFLT: pin_out[i] = dflt_fn[i];
        FN_LINK: pin_out[i] = link_up;
        FN_CRS:  pin_out[i] = crs;
        FN_COL:  pin_out[i] = col;
        FN_TXP: begin
          if (tx_seen) conflict = 1'b1;
          else         pin_out[i] = tx_p;
          tx_seen = 1'b1;
        end
        FN_RXP: begin
          rx_pins[i] = 1'b1;
          if (rx_seen) conflict = 1'b1;
          else         pin_out[i] = rx_p;
          rx_seen = 1'b1;
        end
        default: pin_out[i] = 1'b0;
      endcase
    end
  end

  assert_rx_one_pin_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pin_out & rx_pins) <= 1);
endmodule

// File: rtl/sop_indicator.sv
module sop_indicator
  import sop_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [15:0] reg_wdata,
  input  logic        reg_rd,
  output logic [15:0] reg_rdata,
  input  logic [1:0]  speed,
  input  logic        rx_sym_en,
  input  logic        rx_dv,
  input  logic [7:0]  rxd,
  input  logic        tx_sym_en,
  input  logic        tx_en,
  input  logic [7:0]  txd,
  input  logic        tick_8ns,
  input  logic        link_up,
  input  logic        crs,
  input  logic        col,
  input  logic [3:0]  dflt_fn,
  output logic [3:0]  pin_out
);
  logic [6:0]           ctrl;
  logic [15:0]          rx_dly;
  logic [12:0]          tx_dly;
  logic [NPIN-1:0][3:0] pin_sel;
  logic                 conflict;
  logic                 rx_hit, tx_hit, rx_trig, tx_trig, rx_pulse, tx_pulse;
  logic                 wide;
  logic [LW-1:0]        plen;

  assign wide    = speed[1];
  assign plen    = pulse_len(ctrl[3], ctrl[6:4]);
  assign rx_trig = rx_hit && ctrl[1] && ctrl[2];
  assign tx_trig = tx_hit && ctrl[0] && ctrl[2];

  sop_regs u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
    .rd(reg_rd), .rdata(reg_rdata), .conflict_set(conflict), .ctrl(ctrl),
    .rx_dly(rx_dly), .tx_dly(tx_dly), .pin_sel(pin_sel)
  );

  sop_detect u_rx_det (
    .clk(clk), .rst_n(rst_n), .sym_en(rx_sym_en), .valid(rx_dv), .data(rxd),
    .wide(wide), .hit(rx_hit)
  );

  sop_detect u_tx_det (
    .clk(clk), .rst_n(rst_n), .sym_en(tx_sym_en), .valid(tx_en), .data(txd),
    .wide(wide), .hit(tx_hit)
  );

  sop_pulse u_rx_pulse (
    .clk(clk), .rst_n(rst_n), .trig(rx_trig), .tick(rx_sym_en),
    .delay(rx_delay_pick(rx_dly, speed)), .len(plen), .pulse(rx_pulse)
  );

  sop_pulse u_tx_pulse (
    .clk(clk), .rst_n(rst_n), .trig(tx_trig), .tick(tick_8ns),
    .delay(tx_delay_pick(tx_dly, speed)), .len(plen), .pulse(tx_pulse)
  );

  sop_pinmux u_mux (
    .clk(clk), .rst_n(rst_n), .pin_sel(pin_sel), .dflt_fn(dflt_fn),
    .link_up(link_up), .crs(crs), .col(col), .rx_p(rx_pulse), .tx_p(tx_pulse),
    .pin_out(pin_out), .conflict(conflict)
  );

  assert_trig_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_hit && !ctrl[1]) |=> !(rx_pulse && !$past(rx_pulse) && $past(u_rx_pulse.st_q) == 2'd0));
endmodule

// File: tb/sop_indicator_test.sv
`timescale 1ns/1ps
module sop_indicator_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic [1:0]  speed = 2'd2;
  logic        rx_sym_en = 1'b0, rx_dv = 1'b0, tx_sym_en = 1'b0, tx_en = 1'b0, tick_8ns = 1'b0;
  logic [7:0]  rxd = '0, txd = '0;
  logic        link_up = 1'b0, crs = 1'b0, col = 1'b0;
  logic [3:0]  dflt_fn = 4'b1010;
  logic [3:0]  pin_out;

  int errs = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sop_indicator uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .speed(speed), .rx_sym_en(rx_sym_en),
    .rx_dv(rx_dv), .rxd(rxd), .tx_sym_en(tx_sym_en), .tx_en(tx_en), .txd(txd),
    .tick_8ns(tick_8ns), .link_up(link_up), .crs(crs), .col(col), .dflt_fn(dflt_fn),
    .pin_out(pin_out)
  );

  typedef struct packed {
    logic       is_tx;
    logic [1:0] spd;
    logic [5:0] dly;
    logic       long_en;
    logic [2:0] n;
    logic [1:0] pin;
  } vec_t;

  localparam vec_t VECS [0:7] = '{
    '{1'b0, 2'd2, 6'd0,  1'b0, 3'd0, 2'd1},
    '{1'b0, 2'd1, 6'd3,  1'b1, 3'd0, 2'd0},
    '{1'b0, 2'd0, 6'd31, 1'b0, 3'd0, 2'd3},
    '{1'b1, 2'd2, 6'd15, 1'b0, 3'd0, 2'd2},
    '{1'b1, 2'd1, 6'd5,  1'b1, 3'd2, 2'd0},
    '{1'b1, 2'd0, 6'd20, 1'b0, 3'd0, 2'd3},
    '{1'b0, 2'd2, 6'd63, 1'b1, 3'd7, 2'd2},
    '{1'b1, 2'd2, 6'd0,  1'b1, 3'd1, 2'd1}
  };

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  function automatic logic [15:0] rx_word(logic [1:0] s, logic [5:0] d);
    case (s)
      2'd0:    return {d[4:0], 5'd1, 6'd1};
      2'd1:    return {5'd1, d[4:0], 6'd1};
      default: return {5'd1, 5'd1, d};
    endcase
  endfunction

  function automatic logic [15:0] tx_word(logic [1:0] s, logic [5:0] d);
    case (s)
      2'd0:    return {3'b0, d[4:0], 4'd1, 4'd1};
      2'd1:    return {3'b0, 5'd1, d[3:0], 4'd1};
      default: return {3'b0, 5'd1, 4'd1, d[3:0]};
    endcase
  endfunction

  task automatic put_sym(bit is_tx, logic [7:0] d, logic v);
    if (is_tx) begin txd = d; tx_en = v; tx_sym_en = 1'b1; end
    else       begin rxd = d; rx_dv = v; rx_sym_en = 1'b1; end
  endtask

  task automatic send_sfd(bit is_tx, bit pre_ok, bit sfd_valid);
    logic [7:0] pre, sfd;
    pre = speed[1] ? 8'h55 : 8'h05;
    sfd = speed[1] ? 8'hD5 : 8'h0D;
    if (!pre_ok) pre = 8'h00;
    for (int i = 0; i < 3; i++) begin put_sym(is_tx, pre, 1'b1); @(negedge clk); end
    put_sym(is_tx, sfd, sfd_valid);
    @(negedge clk);
    rx_dv = 1'b0; tx_en = 1'b0; rxd = '0; txd = '0;
  endtask

  task automatic run_frame(bit is_tx, int pin, int period, bit pre_ok, bit sfd_valid,
                           output int lat, output int wid);
    bit hit;
    send_sfd(is_tx, pre_ok, sfd_valid);
    lat = 0; wid = 0; hit = 0;
    for (int g = 0; g < 150; g++) begin
      bit tk;
      if (pin_out[pin]) begin hit = 1; break; end
      tk = ((g % period) == period - 1);
      if (is_tx) tick_8ns = tk; else rx_sym_en = tk;
      if (tk) lat++;
      @(negedge clk);
    end
    if (!hit) lat = -1;
    while (hit && pin_out[pin] && wid < 200) begin wid++; @(negedge clk); end
    rx_sym_en = 1'b0; tx_sym_en = 1'b0; tick_8ns = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int lat, wid;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset values; R8 code 0 passes dflt_fn
    check("R8 reset pins dflt", pin_out, 4'b1010);
    rd(3'd0, d); check("R10 ctrl reset", d, 0);
    rd(3'd7, d); check("R10 status reset", d, 0);

    // R1 R2 R3 R5 R7 table of frames
    foreach (VECS[k]) begin
      vec_t v;
      int ew;
      v = VECS[k];
      speed = v.spd;
      wr(3'd0, {9'b0, v.n, v.long_en, 1'b1, 1'b1, 1'b1});
      wr(3'd1, rx_word(v.spd, v.dly));
      wr(3'd2, tx_word(v.spd, v.dly));
      for (int p = 0; p < 4; p++)
        wr(3'(3 + p), (p == int'(v.pin)) ? (v.is_tx ? 16'd2 : 16'd3) : 16'd0);
      run_frame(v.is_tx, v.pin, 1, 1, 1, lat, wid);
      ew = v.long_en ? 8 * (int'(v.n) + 1) : 1;
      check(v.is_tx ? "R3 tx latency" : "R2 rx latency", lat, v.dly);
      check("R5 pulse width", wid, ew);
    end

    // R10 readback and masks; R7 select widths
    wr(3'd1, 16'hABCD); rd(3'd1, d); check("R10 rx reg", d, 16'hABCD);
    wr(3'd2, 16'hFFFF); rd(3'd2, d); check("R10 tx reg mask", d, 16'h1FFF);
    wr(3'd0, 16'hFFFF); rd(3'd0, d); check("R10 ctrl mask", d, 16'h007F);
    wr(3'd3, 16'hFFFF); rd(3'd3, d); check("R7 pin0 3-bit", d, 7);
    wr(3'd6, 16'hFFFF); rd(3'd6, d); check("R7 pin3 4-bit", d, 15);

    // R8 pin function codes
    dflt_fn = 4'hF; link_up = 1'b1; crs = 1'b1; col = 1'b0;
    wr(3'd3, 16'd6); wr(3'd4, 16'd1); wr(3'd5, 16'd4); wr(3'd6, 16'd8);
    check("R8 codes 6/1/4/8", pin_out, 4'b0110);
    link_up = 1'b0; crs = 1'b0; col = 1'b1; wr(3'd3, 16'd5); wr(3'd6, 16'd0);
    check("R8 codes 5/1/4/0", pin_out, 4'b1001);
    dflt_fn = 4'b1010; col = 1'b0;

    // common rx setup on pin 0, 1000 Mb/s
    speed = 2'd2;
    for (int p = 0; p < 4; p++) wr(3'(3 + p), p == 0 ? 16'd3 : 16'd0);
    wr(3'd1, rx_word(2'd2, 6'd4));

    // R4 enables
    wr(3'd0, 16'h0004); run_frame(0, 0, 1, 1, 1, lat, wid); check("R4 rx disabled", lat, -1);
    wr(3'd0, 16'h0002); run_frame(0, 0, 1, 1, 1, lat, wid); check("R4 trigger disabled", lat, -1);
    wr(3'd0, 16'h0006);
    // R1 qualifiers
    run_frame(0, 0, 1, 0, 1, lat, wid); check("R1 no preamble", lat, -1);
    run_frame(0, 0, 1, 1, 0, lat, wid); check("R1 sfd not valid", lat, -1);
    // R2 counts strobes, not clocks
    run_frame(0, 0, 2, 1, 1, lat, wid); check("R2 strobe every 2", lat, 4);
    // R1 speed code 3 is byte mode, field [5:0]
    speed = 2'd3; wr(3'd1, rx_word(2'd2, 6'd5));
    run_frame(0, 0, 1, 1, 1, lat, wid); check("R1 speed code 3", lat, 5);
    // R3 tx strobes every 2
    speed = 2'd2; wr(3'd0, 16'h0005); wr(3'd2, tx_word(2'd2, 6'd3)); wr(3'd3, 16'd2);
    run_frame(1, 0, 2, 1, 1, lat, wid); check("R3 tick every 2", lat, 3);

    // R6 retrigger ignored
    wr(3'd0, 16'h0006); wr(3'd3, 16'd3); wr(3'd1, rx_word(2'd2, 6'd10));
    send_sfd(0, 1, 1);
    begin
      int cyc, first, cnt;
      logic prev;
      first = -1; cnt = 0; prev = 1'b0;
      for (cyc = 0; cyc < 60; cyc++) begin
        if (pin_out[0] && !prev) begin cnt++; if (first < 0) first = cyc; end
        prev = pin_out[0];
        rx_sym_en = 1'b1;
        if (cyc < 8) begin rx_dv = 1'b1; rxd = ((cyc % 4) == 3) ? 8'hD5 : 8'h55; end
        else begin rx_dv = 1'b0; rxd = '0; end
        @(negedge clk);
      end
      rx_sym_en = 1'b0;
      check("R6 first pulse timing", first, 10);
      check("R6 single pulse", cnt, 1);
    end

    // R9 duplicate selection
    wr(3'd1, rx_word(2'd2, 6'd0)); wr(3'd5, 16'd3);
    rd(3'd7, d); check("R9 status set", d, 1);
    send_sfd(0, 1, 1);
    check("R9 lowest pin carries", pin_out[0], 1);
    check("R9 other pin low", pin_out[2], 0);
    @(negedge clk);
    wr(3'd5, 16'd0); wr(3'd7, 16'd1);
    rd(3'd7, d); check("R9 status cleared", d, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule